// File: doc/BRIEF.md
# Dual-Clock Debug Mailbox

This block passes single 32-bit words between a processor and an external debugger that runs on its own clock. Each direction has one data register and one status flag. The outbound flag means a word written by the processor is waiting for the debugger. The inbound flag means a word written by the debugger is waiting for the processor. A flag is set by the side that produces the word and cleared by the side that consumes it. Every flag change crosses between the two clock domains through a toggle-and-acknowledge handshake.

The processor uses a small register port. It polls a control word, or it relies on two level interrupts: one says it may send, the other says a word has arrived. On the debugger side each direction is a valid/ready stream.

- **Outbound stream.** `dbg_tx_valid` stays high while a word is pending. The word moves, and the flag clears, on the cycle where valid and ready are both high. The debugger may hold ready low for as long as it likes, and the data stays stable during that time.
- **Inbound stream.** `dbg_rx_ready` is high only while the inbound register is empty. A beat is accepted only when valid and ready are both high. A valid beat offered while ready is low is ignored.

Processor register map, selected by `proc_addr`:

| Address | Read | Write |
|---|---|---|
| 0 | Control word | Ignored |
| 1 | — | Outbound data |
| 2 | Inbound data | — |
| 3 | Zero | — |

Top module: `dbgmb_mailbox`

## Requirements
- R1: After reset, with both domain resets applied, the block is empty: both flags are clear, `proc_irq_txfree`=1, `proc_irq_rx`=0, `dbg_tx_valid`=0, `dbg_rx_ready`=1 and `dbg_status`=0.
- R2: A processor read of address 0 returns the outbound flag in bit 1 and the inbound flag in bit 0, with every other bit 0. Processor writes to address 0 change nothing.
- R3: A processor write to address 1 while the outbound flag is clear stores the word and sets the outbound flag. From the next cycle, `proc_irq_txfree` is 0.
- R4: A processor write to address 1 while the outbound flag is set is dropped. The stored word stays unchanged.
- R5: Once the outbound flag is set, `dbg_tx_valid` rises within a few debugger cycles, and `dbg_tx_data` then holds the stored word.
  - A valid-and-ready cycle drops `dbg_tx_valid` on the next debugger cycle.
  - After the synchronizer delay, the outbound flag clears and `proc_irq_txfree` returns to 1.
- R6: A debugger beat with `dbg_rx_valid` and `dbg_rx_ready` both high stores the word and drops `dbg_rx_ready` on the next debugger cycle. Beats offered while ready is low are ignored.
- R7: After an inbound beat, the processor sees `proc_irq_rx`=1 and reads the word at address 2.
  - That read clears the inbound flag, so `proc_irq_rx` is 0 on the next processor cycle.
  - `dbg_rx_ready` returns to 1 after the synchronizer delay.
- R8: A processor read of address 2 while the inbound flag is clear has no effect on either flag or on either side's outputs.
- R9: `dbg_status` gives the debugger's view of both flags: bit 1 is the synchronized outbound flag and bit 0 is the inbound flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_clk | input | 1 | Processor-domain clock |
| proc_rst_n | input | 1 | Processor-domain asynchronous reset, active low |
| proc_wr_en | input | 1 | Register write strobe |
| proc_rd_en | input | 1 | Register read strobe; the read side effect happens at the clock edge |
| proc_addr | input | 2 | Register select |
| proc_wdata | input | 32 | Register write data |
| proc_rdata | output | 32 | Register read data, combinational from the address |
| proc_irq_txfree | output | 1 | High while the outbound register can take a word |
| proc_irq_rx | output | 1 | High while an inbound word is waiting |
| dbg_clk | input | 1 | Debugger-domain clock |
| dbg_rst_n | input | 1 | Debugger-domain asynchronous reset, active low |
| dbg_tx_valid | output | 1 | Outbound word available |
| dbg_tx_ready | input | 1 | Debugger takes the outbound word |
| dbg_tx_data | output | 32 | Outbound word |
| dbg_rx_valid | input | 1 | Debugger offers an inbound word |
| dbg_rx_ready | output | 1 | Inbound register empty |
| dbg_rx_data | input | 32 | Inbound word |
| dbg_status | output | 2 | Debugger view: bit 1 outbound flag, bit 0 inbound flag |

## Verification
The hardest situations to reach are a second word offered while a flag is still set, on either side. These must be dropped rather than overwrite the word in flight. The bench reaches them by issuing a second outbound write right after the first, before the debugger has taken the word. It also holds `dbg_rx_valid` high with new data for a cycle after ready has fallen. It then checks that the first word is still the one delivered at the far side. Every round trip waits for the acknowledge to cross back before the next word starts, so each sweep step also shows that a clear is not lost between the two clocks.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int STAGES   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_TXD  = 2'd1,
    REG_RXD  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_RX_BIT = 0;
  localparam int CTRL_TX_BIT = 1;
endpackage

// File: rtl/dbgmb_sync.sv
module dbgmb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgmb_flag_xing.sv
// A flag raised in the source domain and lowered from the destination
// domain. Source holds a toggle; destination returns it as an acknowledge.
module dbgmb_flag_xing #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic set_i,
  output logic src_flag_o,
  input  logic dst_clk,
  input  logic dst_rst_n,
  input  logic clr_i,
  output logic dst_flag_o
);
  logic src_tog, tog_seen;
  logic dst_ack, ack_seen;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n)  src_tog <= 1'b0;
    else if (set_i)  src_tog <= ~src_tog;
  end

  dbgmb_sync #(.STAGES(STAGES)) u_tog_sync (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(src_tog), .q(tog_seen));

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n)  dst_ack <= 1'b0;
    else if (clr_i)  dst_ack <= tog_seen;
  end

  dbgmb_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_n), .d(dst_ack), .q(ack_seen));

  assign src_flag_o = src_tog ^ ack_seen;
  assign dst_flag_o = tog_seen ^ dst_ack;

  AST_SET_ONLY_WHEN_FREE: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    set_i |-> !src_flag_o); // R4
  AST_CLR_ONLY_WHEN_HELD: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    clr_i |-> dst_flag_o); // R8
  AST_CLR_TAKES_EFFECT: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    clr_i |=> !dst_flag_o); // R5
endmodule

// File: rtl/dbgmb_mailbox.sv
module dbgmb_mailbox
  import dbgmb_pkg::*;
#(
  parameter int SYNC_STAGES = STAGES
) (
  input  logic              proc_clk,
  input  logic              proc_rst_n,
  input  logic              proc_wr_en,
  input  logic              proc_rd_en,
  input  logic [ADDR_W-1:0] proc_addr,
  input  logic [DATA_W-1:0] proc_wdata,
  output logic [DATA_W-1:0] proc_rdata,
  output logic              proc_irq_txfree,
  output logic              proc_irq_rx,
  input  logic              dbg_clk,
  input  logic              dbg_rst_n,
  output logic              dbg_tx_valid,
  input  logic              dbg_tx_ready,
  output logic [DATA_W-1:0] dbg_tx_data,
  input  logic              dbg_rx_valid,
  output logic              dbg_rx_ready,
  input  logic [DATA_W-1:0] dbg_rx_data,
  output logic [1:0]        dbg_status
);
  logic [DATA_W-1:0] tx_word, rx_word;
  logic out_flag_p, out_flag_d;
  logic in_flag_d, in_flag_p;
  logic tx_accept, tx_take, rx_accept, rx_take;

  // processor domain
  assign tx_accept = proc_wr_en && (proc_addr == REG_TXD) && !out_flag_p;
  assign rx_take   = proc_rd_en && (proc_addr == REG_RXD) && in_flag_p;

  always_ff @(posedge proc_clk or negedge proc_rst_n) begin
    if (!proc_rst_n)    tx_word <= '0;
    else if (tx_accept) tx_word <= proc_wdata;
  end

  always_comb begin
    proc_rdata = '0;
    unique case (proc_addr)
      REG_CTRL: begin
        proc_rdata[CTRL_TX_BIT] = out_flag_p;
        proc_rdata[CTRL_RX_BIT] = in_flag_p;
      end
      REG_RXD:  proc_rdata = rx_word;
      default:  proc_rdata = '0;
    endcase
  end

  assign proc_irq_txfree = !out_flag_p;
  assign proc_irq_rx     = in_flag_p;

  // debugger domain
  assign tx_take   = dbg_tx_valid && dbg_tx_ready;
  assign rx_accept = dbg_rx_valid && dbg_rx_ready;

  always_ff @(posedge dbg_clk or negedge dbg_rst_n) begin
    if (!dbg_rst_n)     rx_word <= '0;
    else if (rx_accept) rx_word <= dbg_rx_data;
  end

  assign dbg_tx_valid = out_flag_d;
  assign dbg_tx_data  = tx_word;
  assign dbg_rx_ready = !in_flag_d;
  assign dbg_status   = {out_flag_d, in_flag_d};

  dbgmb_flag_xing #(.STAGES(SYNC_STAGES)) u_out_flag (
    .src_clk(proc_clk), .src_rst_n(proc_rst_n), .set_i(tx_accept), .src_flag_o(out_flag_p),
    .dst_clk(dbg_clk),  .dst_rst_n(dbg_rst_n),  .clr_i(tx_take),   .dst_flag_o(out_flag_d));

  dbgmb_flag_xing #(.STAGES(SYNC_STAGES)) u_in_flag (
    .src_clk(dbg_clk),  .src_rst_n(dbg_rst_n),  .set_i(rx_accept), .src_flag_o(in_flag_d),
    .dst_clk(proc_clk), .dst_rst_n(proc_rst_n), .clr_i(rx_take),   .dst_flag_o(in_flag_p));

  AST_TX_WORD_HELD: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    (out_flag_p && $past(out_flag_p)) |-> $stable(tx_word)); // R4
  AST_TXFREE_DROPS: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    tx_accept |=> !proc_irq_txfree); // R3
  AST_TX_VALID_HOLDS: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
    (dbg_tx_valid && !dbg_tx_ready) |=> (dbg_tx_valid && $stable(dbg_tx_data))); // R5
  AST_RX_READY_FALLS: assert property (@(posedge dbg_clk) disable iff (!dbg_rst_n)
    rx_accept |=> !dbg_rx_ready); // R6
  AST_RX_IRQ_CLEARS: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
    rx_take |=> !proc_irq_rx); // R7
endmodule

// File: tb/test_dbgmb_mailbox.sv
module test_dbgmb_mailbox;
  logic pclk = 0, dclk = 0;
  logic prst_n = 0, drst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, tx_data, rx_data = 0;
  logic irq_txfree, irq_rx, tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  logic [1:0] status;
  int n_chk = 0, n_bad = 0;

  always #2 pclk = ~pclk;
  always #3.5 dclk = ~dclk;

  dbgmb_mailbox i_dbgmb_mailbox (
    .proc_clk(pclk), .proc_rst_n(prst_n), .proc_wr_en(wr_en), .proc_rd_en(rd_en),
    .proc_addr(addr), .proc_wdata(wdata), .proc_rdata(rdata),
    .proc_irq_txfree(irq_txfree), .proc_irq_rx(irq_rx),
    .dbg_clk(dclk), .dbg_rst_n(drst_n), .dbg_tx_valid(tx_valid), .dbg_tx_ready(tx_ready),
    .dbg_tx_data(tx_data), .dbg_rx_valid(rx_valid), .dbg_rx_ready(rx_ready),
    .dbg_rx_data(rx_data), .dbg_status(status));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int i);
    if (i == 0) return 32'h0;
    if (i == 1) return 32'hFFFF_FFFF;
    return (i * 32'h9E37_79B9) ^ (32'h0101_0101 << (i % 8));
  endfunction

  task automatic pwrite(logic [1:0] a, logic [31:0] d);
    @(negedge pclk); wr_en = 1; addr = a; wdata = d;
    @(negedge pclk); wr_en = 0;
  endtask

  task automatic pread(logic [1:0] a, output logic [31:0] d);
    @(negedge pclk); rd_en = 1; addr = a;
    #0.5 d = rdata;
    @(negedge pclk); rd_en = 0;
  endtask

  task automatic wait_d(input bit which);
    for (int k = 0; k < 40; k++) begin
      if ((which ? tx_valid : rx_ready) === 1'b1) break;
      @(negedge dclk);
    end
  endtask

  task automatic wait_p(input bit which);
    for (int k = 0; k < 40; k++) begin
      if ((which ? irq_rx : irq_txfree) === 1'b1) break;
      @(negedge pclk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge dclk);
    prst_n = 1; drst_n = 1;
    @(negedge pclk);
    // R1 reset state
    check("R1 irq_txfree", irq_txfree, 1);
    check("R1 irq_rx", irq_rx, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 rx_ready", rx_ready, 1);
    check("R1 status", status, 0);
    pread(2'd0, r); check("R1 ctrl", r, 0);
    // R2 control writes ignored
    pwrite(2'd0, 32'hFFFF_FFFF);
    pread(2'd0, r); check("R2 ctrl write ignored", r, 0);
    check("R2 txfree after ctrl write", irq_txfree, 1);

    for (int i = 0; i < 10; i++) begin
      // outbound
      pwrite(2'd1, pat(i));
      check("R3 txfree low", irq_txfree, 0);
      pwrite(2'd1, ~pat(i));
      pread(2'd0, r); check("R2 ctrl tx bit", r, 32'h2);
      @(negedge dclk); wait_d(1);
      check("R5 tx_valid", tx_valid, 1);
      check("R4 tx_data kept", tx_data, pat(i));
      check("R9 status tx", status, 2'b10);
      tx_ready = 1; @(negedge dclk); tx_ready = 0;
      check("R5 tx_valid drops", tx_valid, 0);
      @(negedge pclk); wait_p(0);
      check("R5 txfree back", irq_txfree, 1);
      pread(2'd0, r); check("R2 ctrl idle", r, 0);
      // inbound
      @(negedge dclk); wait_d(0);
      check("R6 rx_ready idle", rx_ready, 1);
      rx_valid = 1; rx_data = pat(i + 3);
      @(negedge dclk);
      check("R6 rx_ready drops", rx_ready, 0);
      check("R9 status rx", status, 2'b01);
      rx_data = ~pat(i + 3);
      @(negedge dclk); rx_valid = 0;
      @(negedge pclk); wait_p(1);
      check("R7 irq_rx", irq_rx, 1);
      pread(2'd0, r); check("R2 ctrl rx bit", r, 32'h1);
      pread(2'd2, r); check("R6 R7 rx word", r, pat(i + 3));
      check("R7 irq_rx clears", irq_rx, 0);
      @(negedge dclk); wait_d(0);
      check("R7 rx_ready back", rx_ready, 1);
      check("R9 status idle", status, 2'b00);
    end

    // R8 read of empty inbound register
    pread(2'd2, r);
    repeat (8) @(negedge dclk);
    check("R8 irq_rx", irq_rx, 0);
    check("R8 rx_ready", rx_ready, 1);
    check("R8 status", status, 0);
    pread(2'd0, r); check("R8 ctrl", r, 0);
    pread(2'd3, r); check("R2 unused addr", r, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule